// File: doc/BRIEF.md
# Result Ring Interrupt Coalescer

This block keeps count of the result descriptors waiting in a circular result ring. A packet engine fills the ring and a host empties it. Each time the engine stores a descriptor it sends a one-cycle pulse, and the count rises by one. The host removes entries in batches: it writes a count to a decrement port, and the count falls by that amount. The descriptor memory and its contents are not part of this block.

Two interrupt sources let the host service the ring in batches instead of once per descriptor:

- The threshold interrupt is a level signal. It is high while the count is strictly above a programmed threshold.
- The timeout interrupt covers entries left below the threshold. A cycle-count timer starts when a descriptor arrives while the timer is idle. Every host decrement write restarts it. When it expires with entries still present, a pending timeout is latched. That pending state clears when the host acknowledges it or when the ring empties.

A full flag shows when the count equals the programmed ring size. Two sticky flags record misuse: a descriptor pulse while the ring is full, and a decrement larger than the count.

Top module: `ring_irq_coalescer`

## Requirements
- R1: After reset, fill_level, irq_thresh, irq_timeout, ring_full, err_overflow and err_underflow are all 0.
- R2: ring_full is 1 exactly while fill_level equals cfg_ring_size; a ring size of 256 is supported.
- R3: A wr_pulse sampled while the ring is not full raises fill_level by one, visible after that clock edge.
- R4: irq_thresh is 1 exactly when cfg_thr_en is 1 and fill_level is strictly greater than cfg_thresh; with a threshold of 32, a level of 32 gives 0 and a level of 33 gives 1.
- R5: A host_dec_valid write lowers fill_level by host_dec_count at the following edge; a descriptor pulse accepted in the same cycle is also counted (new level = old + 1 - count).
- R6: irq_thresh falls in the same cycle fill_level stops exceeding the threshold, while the remaining entries stay counted (33 minus 8 leaves 25).
- R7: When a descriptor is accepted while the timer is idle and the ring stays non-empty with no decrement write, irq_timeout (if enabled) rises exactly cfg_timeout clock edges after the edge that accepted the descriptor; further descriptors do not restart the timer.
- R8: Every host decrement write that leaves entries in the ring restarts the timer, so the timeout rises exactly cfg_timeout edges after the write's edge.
- R9: The timeout interrupt asserts even when fill_level is at or below the threshold; irq_timeout is the latched pending timeout gated by cfg_tmo_en, and it appears immediately if the enable is set while a timeout is pending.
- R10: The pending timeout clears after a host_tmo_ack pulse, or when fill_level reaches zero; with fill_level 0, irq_timeout is 0.
- R11: A wr_pulse while the ring is full leaves fill_level unchanged and sets err_overflow, which stays 1 until reset.
- R12: A decrement larger than the current level (plus any same-cycle accepted pulse) sets fill_level to 0 and sets err_underflow, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_pulse | input | 1 | One-cycle pulse per descriptor written by the engine |
| host_dec_valid | input | 1 | Host decrement write strobe |
| host_dec_count | input | LVL_W | Number of entries the host removes |
| host_tmo_ack | input | 1 | Host acknowledge of the pending timeout |
| cfg_ring_size | input | LVL_W | Ring capacity in entries (at most MAX_RING) |
| cfg_thresh | input | LVL_W | Fill threshold |
| cfg_timeout | input | TMO_W | Timeout length in clock cycles (at least 1) |
| cfg_thr_en | input | 1 | Threshold interrupt enable |
| cfg_tmo_en | input | 1 | Timeout interrupt enable |
| fill_level | output | LVL_W | Entries currently waiting |
| irq_thresh | output | 1 | Threshold interrupt |
| irq_timeout | output | 1 | Timeout interrupt |
| ring_full | output | 1 | Level equals ring size |
| err_overflow | output | 1 | Sticky: pulse dropped on a full ring |
| err_underflow | output | 1 | Sticky: decrement exceeded level |

## Verification
The hardest state to reach from the ports is a timeout that is pending while the threshold interrupt is low and entries remain. Reaching it needs a fill past the threshold, a partial drain, and then a wait whose length is counted from the last decrement write rather than from the first descriptor. The bench fills 33 entries against a threshold of 32 and drains 8. It then samples irq_timeout one cycle before and exactly at the expiry counted from the decrement edge, which shows the restart. A separate case holds the timeout enable low through expiry, then raises it to expose the latched pending state.

// File: rtl/rcoal_pkg.sv
package rcoal_pkg;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic accept;     // pulse counted this cycle
        logic drop;       // pulse lost on a full ring
        logic under;      // decrement exceeded available entries
        logic next_zero;  // ring empty after this edge
    } lvl_evt_t;

    function automatic logic tmr_expires(input logic [31:0] cnt, input logic [31:0] lim);
        return (cnt + 32'd1) >= lim;
    endfunction

endpackage

// File: rtl/rcoal_level.sv
module rcoal_level
    import rcoal_pkg::*;
#(
    parameter int LVL_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_req,
    input  logic             dec_req,
    input  logic [LVL_W-1:0] dec_cnt,
    input  logic [LVL_W-1:0] ring_size,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output lvl_evt_t         evt,
    output logic             err_ovf,
    output logic             err_unf
);
    logic [LVL_W:0]   sum;
    logic [LVL_W-1:0] nxt;

    always_comb begin
        full          = level >= ring_size;
        evt.accept    = inc_req && !full;
        evt.drop      = inc_req && full;
        sum           = {1'b0, level} + {{LVL_W{1'b0}}, evt.accept};
        evt.under     = dec_req && ({1'b0, dec_cnt} > sum);
        if (!dec_req)
            nxt = sum[LVL_W-1:0];
        else if (evt.under)
            nxt = '0;
        else
            nxt = sum[LVL_W-1:0] - dec_cnt;
        evt.next_zero = (nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level   <= '0;
            err_ovf <= 1'b0;
            err_unf <= 1'b0;
        end else begin
            level <= nxt;
            if (evt.drop)  err_ovf <= 1'b1;
            if (evt.under) err_unf <= 1'b1;
        end
    end
endmodule

// File: rtl/rcoal_timer.sv
module rcoal_timer
    import rcoal_pkg::*;
#(
    parameter int TMO_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             restart,
    input  logic             next_zero,
    input  logic             ack,
    input  logic [TMO_W-1:0] limit,
    output logic             pending
);
    tmr_state_e       st;
    logic [TMO_W-1:0] cnt;
    logic             done;
    logic             expire;

    always_comb begin
        done   = tmr_expires(32'(cnt), 32'(limit));
        expire = (st == TMR_RUN) && done && !next_zero && !restart;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= TMR_IDLE;
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            if (next_zero) begin
                st  <= TMR_IDLE;
                cnt <= '0;
            end else if (restart) begin
                st  <= TMR_RUN;
                cnt <= '0;
            end else begin
                case (st)
                    TMR_IDLE: begin
                        if (start) begin
                            st  <= TMR_RUN;
                            cnt <= '0;
                        end
                    end
                    TMR_RUN: begin
                        if (done) begin
                            st  <= TMR_IDLE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= TMR_IDLE;
                endcase
            end

            if (next_zero)
                pending <= 1'b0;
            else if (expire)
                pending <= 1'b1;
            else if (ack)
                pending <= 1'b0;
        end
    end
endmodule

// File: rtl/ring_irq_coalescer.sv
module ring_irq_coalescer
    import rcoal_pkg::*;
#(
    parameter int MAX_RING = 1024,
    parameter int TMO_W    = 20,
    localparam int LVL_W   = $clog2(MAX_RING + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_pulse,
    input  logic             host_dec_valid,
    input  logic [LVL_W-1:0] host_dec_count,
    input  logic             host_tmo_ack,
    input  logic [LVL_W-1:0] cfg_ring_size,
    input  logic [LVL_W-1:0] cfg_thresh,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic             cfg_thr_en,
    input  logic             cfg_tmo_en,
    output logic [LVL_W-1:0] fill_level,
    output logic             irq_thresh,
    output logic             irq_timeout,
    output logic             ring_full,
    output logic             err_overflow,
    output logic             err_underflow
);
    lvl_evt_t evt;
    logic     tmo_pending;

    rcoal_level #(.LVL_W(LVL_W)) u_level (
        .clk      (clk),
        .rst      (rst),
        .inc_req  (wr_pulse),
        .dec_req  (host_dec_valid),
        .dec_cnt  (host_dec_count),
        .ring_size(cfg_ring_size),
        .level    (fill_level),
        .full     (ring_full),
        .evt      (evt),
        .err_ovf  (err_overflow),
        .err_unf  (err_underflow)
    );

    rcoal_timer #(.TMO_W(TMO_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (evt.accept),
        .restart  (host_dec_valid),
        .next_zero(evt.next_zero),
        .ack      (host_tmo_ack),
        .limit    (cfg_timeout),
        .pending  (tmo_pending)
    );

    always_comb begin
        irq_thresh  = cfg_thr_en && (fill_level > cfg_thresh);
        irq_timeout = cfg_tmo_en && tmo_pending;
    end
endmodule

// File: rtl/rcoal_checker.sv
module rcoal_checker #(
    parameter int LVL_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_pulse,
    input logic             host_dec_valid,
    input logic [LVL_W-1:0] host_dec_count,
    input logic [LVL_W-1:0] cfg_thresh,
    input logic             cfg_thr_en,
    input logic [LVL_W-1:0] fill_level,
    input logic             irq_thresh,
    input logic             irq_timeout,
    input logic             ring_full,
    input logic             err_overflow,
    input logic             err_underflow
);
    assert_thr_level_R4: assert property (@(posedge clk) disable iff (rst)
        irq_thresh |-> (cfg_thr_en && fill_level > cfg_thresh));

    assert_inc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && !ring_full && !host_dec_valid) |=> fill_level == $past(fill_level) + 1'b1);

    assert_dec_step_R5: assert property (@(posedge clk) disable iff (rst)
        (host_dec_valid && !wr_pulse && host_dec_count <= fill_level)
        |=> fill_level == $past(fill_level) - $past(host_dec_count));

    assert_tmo_empty_R10: assert property (@(posedge clk) disable iff (rst)
        (fill_level == '0) |-> !irq_timeout);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && ring_full && !host_dec_valid) |=> ($stable(fill_level) && err_overflow));

    assert_underflow_sat_R12: assert property (@(posedge clk) disable iff (rst)
        (host_dec_valid && !wr_pulse && host_dec_count > fill_level)
        |=> (fill_level == '0 && err_underflow));
endmodule

bind ring_irq_coalescer rcoal_checker #(.LVL_W(LVL_W)) u_rcoal_checker (.*);

// File: tb/test_ring_irq_coalescer.sv
module test_ring_irq_coalescer;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 11;
    localparam int TW = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_pulse;
    logic          host_dec_valid;
    logic [LW-1:0] host_dec_count;
    logic          host_tmo_ack;
    logic [LW-1:0] cfg_ring_size;
    logic [LW-1:0] cfg_thresh;
    logic [TW-1:0] cfg_timeout;
    logic          cfg_thr_en;
    logic          cfg_tmo_en;
    logic [LW-1:0] fill_level;
    logic          irq_thresh;
    logic          irq_timeout;
    logic          ring_full;
    logic          err_overflow;
    logic          err_underflow;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_irq_coalescer i_ring_irq_coalescer (.*);

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_pulse = 0; host_dec_valid = 0; host_dec_count = '0; host_tmo_ack = 0;
        cfg_ring_size = 11'd256; cfg_thresh = 11'd32; cfg_timeout = 20'd500;
        cfg_thr_en = 1; cfg_tmo_en = 1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push_n(input int n);
        @(negedge clk) wr_pulse = 1'b1;
        repeat (n) @(negedge clk);
        wr_pulse = 1'b0;
    endtask

    task automatic dec(input int n);
        @(negedge clk);
        host_dec_valid = 1'b1; host_dec_count = LW'(n);
        @(negedge clk);
        host_dec_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R1 level", int'(fill_level), 0);
        check("R1 irqs", int'({irq_thresh, irq_timeout}), 0);
        check("R1 flags", int'({ring_full, err_overflow, err_underflow}), 0);
    endtask

    task automatic t_threshold_and_timeout();
        do_reset();
        push_n(32);
        check("R3 level after 32", int'(fill_level), 32);
        check("R4 no irq at 32", int'(irq_thresh), 0);
        push_n(1);
        check("R4 irq at 33", int'(irq_thresh), 1);
        dec(8);
        check("R5 level 25", int'(fill_level), 25);
        check("R6 irq drops", int'(irq_thresh), 0);
        repeat (499) @(negedge clk);
        check("R8 restart no timeout yet", int'(irq_timeout), 0);
        @(negedge clk);
        check("R9 timeout below threshold", int'(irq_timeout), 1);
        @(negedge clk) host_tmo_ack = 1'b1;
        @(negedge clk) host_tmo_ack = 1'b0;
        check("R10 ack clears", int'(irq_timeout), 0);
        check("R10 level kept", int'(fill_level), 25);
    endtask

    task automatic t_timeout_start();
        do_reset();
        cfg_timeout = 20'd50;
        push_n(1);
        push_n(1);
        repeat (47) @(negedge clk);
        check("R7 before expiry", int'(irq_timeout), 0);
        @(negedge clk);
        check("R7 expiry from first write", int'(irq_timeout), 1);
        dec(2);
        check("R10 empty clears", int'(irq_timeout), 0);
        repeat (60) @(negedge clk);
        check("R10 idle at zero", int'(irq_timeout), 0);
    endtask

    task automatic t_enables();
        do_reset();
        cfg_thr_en = 0; cfg_tmo_en = 0; cfg_timeout = 20'd40;
        push_n(33);
        check("R4 thr disabled", int'(irq_thresh), 0);
        repeat (20) @(negedge clk);
        check("R9 tmo disabled", int'(irq_timeout), 0);
        cfg_tmo_en = 1; cfg_thr_en = 1;
        #1;
        check("R9 pending shown", int'(irq_timeout), 1);
        check("R4 thr enabled", int'(irq_thresh), 1);
    endtask

    task automatic t_simultaneous();
        do_reset();
        push_n(5);
        @(negedge clk);
        wr_pulse = 1; host_dec_valid = 1; host_dec_count = 11'd2;
        @(negedge clk);
        wr_pulse = 0; host_dec_valid = 0;
        check("R5 inc and dec", int'(fill_level), 4);
    endtask

    task automatic t_full_overflow();
        do_reset();
        push_n(255);
        check("R2 not full at 255", int'(ring_full), 0);
        push_n(1);
        check("R2 full at 256", int'(ring_full), 1);
        push_n(1);
        check("R11 level held", int'(fill_level), 256);
        check("R11 overflow flag", int'(err_overflow), 1);
        dec(6);
        check("R11 flag sticky", int'(err_overflow), 1);
        check("R2 full cleared", int'(ring_full), 0);
    endtask

    task automatic t_underflow();
        do_reset();
        push_n(3);
        dec(5);
        check("R12 saturate zero", int'(fill_level), 0);
        check("R12 underflow flag", int'(err_underflow), 1);
        push_n(1);
        check("R12 flag sticky", int'(err_underflow), 1);
        check("R3 counts after", int'(fill_level), 1);
    endtask

    initial begin
        t_reset();
        t_threshold_and_timeout();
        t_timeout_start();
        t_enables();
        t_simultaneous();
        t_full_overflow();
        t_underflow();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule